// File: doc/BRIEF.md
# Link Rate and Lane Selector

This block picks how many lanes and which per-lane link rate a display link should run to carry a requested pixel clock. Software or a mode-setting engine supplies the pixel clock in kHz, the sink's advertised lane limit and top link rate, the colour depth per component, a flag saying whether the sink accepts the highest rate, and an override that pins the rate to the middle value. The block answers with a lane count, a rate in kHz and a flag telling whether the resulting mode may be used.

The search favours the narrowest link first and the slowest rate second. A configuration is judged to carry the mode when the pixel clock does not exceed rate times lanes times eight divided by bits per pixel, with integer division. The inputs are captured when `start_i` is accepted, the search then walks one candidate per clock, and `done_o` pulses for one cycle when the result registers are updated. The results then hold until the next search ends.

Top module: `link_cfg_select`

## Requirements
- R1: Bits per pixel is 24 when `bpc_i` is 0 and three times `bpc_i` otherwise.
- R2: A candidate (rate, lanes) fits when `pix_clk_khz_i` is at most floor(rate × lanes × 8 / bpp); equality fits.
- R3: The lane count starts at 1 and doubles while it is below the sink's lane limit and the current count does not fit at the sink's top rate; the result is always 1, 2 or 4.
- R4: A sink lane limit other than 1, 2 or 4 is treated as 1.
- R5: With the chosen lane count, the rate is 162000 kHz if it fits, otherwise 270000 kHz if it fits.
- R6: 540000 kHz is selected as a fitting candidate only when `hi_rate_cap_i` is 1.
- R7: When no candidate fits, the output rate equals the sink's top rate `sink_rate_khz_i`.
- R8: When `force_mid_rate_i` is 1 the rate is 270000 kHz whatever the pixel clock; the lane count still follows R3.
- R9: `mode_ok_o` is 0 exactly when the output rate is 540000 kHz and `hi_rate_cap_i` was 0; otherwise it is 1.
- R10: With `start_i` sampled at clock edge 0, `done_o` is high for exactly one cycle, following edge N = (lane counts examined) + (rates examined), where a forced rate counts as one rate examined and the fallback of R7 or a 540000 kHz choice counts as three; the results change only at that edge.
- R11: `start_i` is ignored while a search is in progress, and inputs are sampled only when the search starts.
- R12: During and after reset, `done_o`, `lanes_o`, `rate_khz_o` and `mode_ok_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search; accepted only when idle |
| pix_clk_khz_i | input | PIX_W | Requested pixel clock in kHz |
| sink_lanes_i | input | LANE_W | Sink lane limit (1, 2 or 4) |
| sink_rate_khz_i | input | RATE_W | Sink top link rate in kHz |
| bpc_i | input | BPC_W | Bits per colour component, 0 means default |
| hi_rate_cap_i | input | 1 | Sink accepts 540000 kHz |
| force_mid_rate_i | input | 1 | Pin the rate to 270000 kHz |
| done_o | output | 1 | One-cycle pulse when results update |
| lanes_o | output | LANE_W | Chosen lane count |
| rate_khz_o | output | RATE_W | Chosen link rate in kHz |
| mode_ok_o | output | 1 | Mode may be used |

## Verification
A wrong lane step or a wrong rate index inside the search does not stay hidden: it either moves the `done_o` pulse to another cycle or leaves a wrong lane count or rate in the result registers at that pulse. Because the bench predicts the exact pulse cycle and compares `done_o` on every clock, a skipped or repeated step shows up within the same search, at most a few cycles after start. Stale capture of inputs shows up as results that match the inputs of an earlier search, and a disturbed idle state shows up as result registers moving with no pulse.

// File: rtl/link_cfg_pkg.sv
package link_cfg_pkg;

    localparam int RATE_LO_KHZ  = 162000;
    localparam int RATE_MID_KHZ = 270000;
    localparam int RATE_HI_KHZ  = 540000;
    localparam int DEFAULT_BPP  = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LANE,
        ST_RATE,
        ST_DONE
    } lcs_state_e;

    typedef enum logic [1:0] {
        RIDX_LO  = 2'd0,
        RIDX_MID = 2'd1,
        RIDX_HI  = 2'd2
    } lcs_ridx_e;

    // Bits per pixel from bits per colour component (R1).
    function automatic int bpp_of(input int bpc);
        return (bpc == 0) ? DEFAULT_BPP : 3 * bpc;
    endfunction

endpackage

// File: rtl/lcs_lane_clamp.sv
module lcs_lane_clamp #(
    parameter int LANE_W = 3
) (
    input  logic [LANE_W-1:0] raw_i,
    output logic [LANE_W-1:0] lanes_o
);
    localparam logic [LANE_W-1:0] ONE  = LANE_W'(1);
    localparam logic [LANE_W-1:0] TWO  = LANE_W'(2);
    localparam logic [LANE_W-1:0] FOUR = LANE_W'(4);

    always_comb begin
        if (raw_i == ONE || raw_i == TWO || raw_i == FOUR)
            lanes_o = raw_i;
        else
            lanes_o = ONE;
    end
endmodule

// File: rtl/lcs_fit_check.sv
module lcs_fit_check #(
    parameter int PIX_W  = 20,
    parameter int RATE_W = 20,
    parameter int LANE_W = 3,
    parameter int BPP_W  = 6
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [LANE_W-1:0] lanes_i,
    input  logic [BPP_W-1:0]  bpp_i,
    output logic              fits_o
);
    // pix <= floor(rate*lanes*8/bpp)  <=>  pix*bpp <= rate*lanes*8
    localparam int DEM_W = PIX_W + BPP_W;
    localparam int SUP_W = RATE_W + LANE_W + 3;
    localparam int CMP_W = ((DEM_W > SUP_W) ? DEM_W : SUP_W) + 1;

    logic [CMP_W-1:0] demand;
    logic [CMP_W-1:0] supply;

    assign demand = CMP_W'(pix_i) * CMP_W'(bpp_i);
    assign supply = (CMP_W'(rate_i) * CMP_W'(lanes_i)) << 3;
    assign fits_o = (demand <= supply);
endmodule

// File: rtl/link_cfg_select.sv
module link_cfg_select
    import link_cfg_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int RATE_W = 20,
    parameter int LANE_W = 3,
    parameter int BPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PIX_W-1:0]  pix_clk_khz_i,
    input  logic [LANE_W-1:0] sink_lanes_i,
    input  logic [RATE_W-1:0] sink_rate_khz_i,
    input  logic [BPC_W-1:0]  bpc_i,
    input  logic              hi_rate_cap_i,
    input  logic              force_mid_rate_i,
    output logic              done_o,
    output logic [LANE_W-1:0] lanes_o,
    output logic [RATE_W-1:0] rate_khz_o,
    output logic              mode_ok_o
);
    localparam int BPP_W = BPC_W + 2;
    localparam logic [RATE_W-1:0] R_LO  = RATE_W'(RATE_LO_KHZ);
    localparam logic [RATE_W-1:0] R_MID = RATE_W'(RATE_MID_KHZ);
    localparam logic [RATE_W-1:0] R_HI  = RATE_W'(RATE_HI_KHZ);

    lcs_state_e        state_q;
    lcs_ridx_e         ridx_q;
    logic [PIX_W-1:0]  pix_q;
    logic [LANE_W-1:0] max_lanes_q;
    logic [RATE_W-1:0] max_rate_q;
    logic [BPP_W-1:0]  bpp_q;
    logic              hicap_q;
    logic              force_q;
    logic [LANE_W-1:0] lane_w_q;

    logic [LANE_W-1:0] lanes_clamped;
    logic [BPP_W-1:0]  bpp_in;
    logic [RATE_W-1:0] cand_rate;
    logic              fit_at_max;
    logic              fit_at_cand;
    logic              finish_now;
    logic [RATE_W-1:0] finish_rate;
    logic              idle_w;

    assign bpp_in = BPP_W'(bpp_of(int'(bpc_i)));
    assign idle_w = (state_q == ST_IDLE);
    assign done_o = (state_q == ST_DONE);

    lcs_lane_clamp #(.LANE_W(LANE_W)) u_clamp (
        .raw_i  (sink_lanes_i),
        .lanes_o(lanes_clamped)
    );

    always_comb begin
        case (ridx_q)
            RIDX_LO:  cand_rate = R_LO;
            RIDX_MID: cand_rate = R_MID;
            default:  cand_rate = R_HI;
        endcase
    end

    lcs_fit_check #(.PIX_W(PIX_W), .RATE_W(RATE_W), .LANE_W(LANE_W), .BPP_W(BPP_W)) u_fit_lane (
        .pix_i  (pix_q),
        .rate_i (max_rate_q),
        .lanes_i(lane_w_q),
        .bpp_i  (bpp_q),
        .fits_o (fit_at_max)
    );

    lcs_fit_check #(.PIX_W(PIX_W), .RATE_W(RATE_W), .LANE_W(LANE_W), .BPP_W(BPP_W)) u_fit_rate (
        .pix_i  (pix_q),
        .rate_i (cand_rate),
        .lanes_i(lane_w_q),
        .bpp_i  (bpp_q),
        .fits_o (fit_at_cand)
    );

    // Rate decision for the current candidate.
    always_comb begin
        finish_now  = 1'b0;
        finish_rate = max_rate_q;
        if (state_q == ST_RATE) begin
            if (force_q) begin
                finish_now  = 1'b1;
                finish_rate = R_MID;
            end else if (ridx_q == RIDX_HI) begin
                finish_now  = 1'b1;
                finish_rate = (hicap_q && fit_at_cand) ? R_HI : max_rate_q;
            end else if (fit_at_cand) begin
                finish_now  = 1'b1;
                finish_rate = cand_rate;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            ridx_q      <= RIDX_LO;
            pix_q       <= '0;
            max_lanes_q <= '0;
            max_rate_q  <= '0;
            bpp_q       <= '0;
            hicap_q     <= 1'b0;
            force_q     <= 1'b0;
            lane_w_q    <= '0;
            lanes_o     <= '0;
            rate_khz_o  <= '0;
            mode_ok_o   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        pix_q       <= pix_clk_khz_i;
                        max_lanes_q <= lanes_clamped;
                        max_rate_q  <= sink_rate_khz_i;
                        bpp_q       <= bpp_in;
                        hicap_q     <= hi_rate_cap_i;
                        force_q     <= force_mid_rate_i;
                        lane_w_q    <= LANE_W'(1);
                        state_q     <= ST_LANE;
                    end
                end
                ST_LANE: begin
                    if (lane_w_q < max_lanes_q && !fit_at_max) begin
                        lane_w_q <= lane_w_q << 1;
                    end else begin
                        ridx_q  <= RIDX_LO;
                        state_q <= ST_RATE;
                    end
                end
                ST_RATE: begin
                    if (finish_now) begin
                        lanes_o    <= lane_w_q;
                        rate_khz_o <= finish_rate;
                        mode_ok_o  <= !(finish_rate == R_HI && !hicap_q);
                        state_q    <= ST_DONE;
                    end else begin
                        ridx_q <= (ridx_q == RIDX_LO) ? RIDX_MID : RIDX_HI;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_cfg_select_chk.sv
module link_cfg_select_chk #(
    parameter int RATE_W = 20,
    parameter int LANE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              idle_w,
    input logic              force_q,
    input logic              done_o,
    input logic [LANE_W-1:0] lanes_o,
    input logic [RATE_W-1:0] rate_khz_o,
    input logic              mode_ok_o
);
    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_lanes_pow2_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones(lanes_o) == 1 && lanes_o <= LANE_W'(4)));

    assert_force_mid_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o && force_q) |-> (rate_khz_o == RATE_W'(270000)));

    assert_ok_below_hi_R9: assert property (@(posedge clk) disable iff (rst)
        (done_o && rate_khz_o != RATE_W'(540000)) |-> mode_ok_o);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (idle_w && !start_i) |=> ($stable(rate_khz_o) && $stable(lanes_o) && $stable(mode_ok_o) && !done_o));
endmodule

bind link_cfg_select link_cfg_select_chk #(.RATE_W(RATE_W), .LANE_W(LANE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .idle_w    (idle_w),
    .force_q   (force_q),
    .done_o    (done_o),
    .lanes_o   (lanes_o),
    .rate_khz_o(rate_khz_o),
    .mode_ok_o (mode_ok_o)
);

// File: tb/link_cfg_select_test.sv
module link_cfg_select_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] pix = '0;
    logic [2:0]  slanes = '0;
    logic [19:0] srate = '0;
    logic [3:0]  bpc = '0;
    logic        hicap = 1'b0;
    logic        force_mid = 1'b0;
    logic        done;
    logic [2:0]  lanes;
    logic [19:0] rate;
    logic        ok;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    link_cfg_select uut (
        .clk(clk), .rst(rst), .start_i(start), .pix_clk_khz_i(pix),
        .sink_lanes_i(slanes), .sink_rate_khz_i(srate), .bpc_i(bpc),
        .hi_rate_cap_i(hicap), .force_mid_rate_i(force_mid),
        .done_o(done), .lanes_o(lanes), .rate_khz_o(rate), .mode_ok_o(ok)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got %0d cycles expected below 60000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference built from the requirements.
    function automatic void model(input int p, input int lraw, input int rmax, input int b,
                                  input bit hc, input bit fm,
                                  output int el, output int er, output bit eok, output int lat);
        int bpp, lmax, steps, rs;
        bpp  = (b == 0) ? 24 : 3 * b;                              // R1
        lmax = (lraw == 1 || lraw == 2 || lraw == 4) ? lraw : 1;  // R4
        el = 1; steps = 1;
        while (el < lmax && longint'(p) > (longint'(rmax) * el * 8) / bpp) begin // R2, R3
            el = el * 2; steps++;
        end
        if (fm) begin er = 270000; rs = 1; end                    // R8
        else if (longint'(p) <= (longint'(162000) * el * 8) / bpp) begin er = 162000; rs = 1; end // R5
        else if (longint'(p) <= (longint'(270000) * el * 8) / bpp) begin er = 270000; rs = 2; end
        else if (hc && longint'(p) <= (longint'(540000) * el * 8) / bpp) begin er = 540000; rs = 3; end // R6
        else begin er = rmax; rs = 3; end                        // R7
        eok = !(er == 540000 && !hc);                             // R9
        lat = steps + rs + 1;                                     // R10
    endfunction

    task automatic run(input string req, input int p, input int lraw, input int rmax,
                       input int b, input bit hc, input bit fm, input bit disturb);
        int el, er, lat;
        bit eok;
        model(p, lraw, rmax, b, hc, fm, el, er, eok, lat);
        @(negedge clk);
        pix = 20'(p); slanes = 3'(lraw); srate = 20'(rmax); bpc = 4'(b);
        hicap = hc; force_mid = fm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= lat + 3; c++) begin
            if (disturb && c == 1) begin
                start = 1'b1; pix = pix ^ 20'h3a5f1; slanes = 3'd4; force_mid = ~fm; // R11
            end
            if (disturb && c == 2) start = 1'b0;
            chk(req, "done timing R10", done, (c == lat));
            if (c >= lat) begin
                chk(req, "lanes R3", lanes, el);
                chk(req, "rate R5", rate, er);
                chk(req, "mode_ok R9", ok, eok);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "done after reset", done, 0);
        chk("R12", "lanes after reset", lanes, 0);
        chk("R12", "rate after reset", rate, 0);
        chk("R12", "ok after reset", ok, 0);

        run("R3", 100000, 4, 270000, 8, 0, 0, 0);   // two lanes, low rate
        run("R1", 100000, 4, 270000, 0, 0, 0, 0);   // bpc 0 behaves as 24 bpp
        run("R1", 100000, 4, 270000, 10, 0, 0, 0);  // 30 bpp
        run("R2", 90000, 4, 270000, 8, 0, 0, 0);    // exact fit on one lane at mid rate
        run("R2", 90001, 4, 270000, 8, 0, 0, 0);    // one over: two lanes
        run("R6", 500000, 4, 540000, 8, 1, 0, 0);   // high rate allowed
        run("R9", 500000, 4, 540000, 8, 0, 0, 0);   // fallback to 540000, invalid
        run("R7", 900000, 4, 270000, 8, 1, 0, 0);   // nothing fits
        run("R4", 100000, 3, 270000, 8, 0, 0, 0);   // odd limit treated as 1
        run("R4", 50000, 0, 162000, 8, 0, 0, 0);
        run("R8", 20000, 2, 540000, 8, 1, 1, 0);    // forced mid rate
        run("R8", 600000, 4, 540000, 6, 1, 1, 0);
        run("R5", 150000, 2, 270000, 6, 0, 0, 0);   // 18 bpp floor
        run("R11", 300000, 2, 270000, 8, 0, 0, 1);  // start during search ignored

        for (int i = 0; i < 40; i++) begin
            int rsel, rm;
            rsel = $urandom_range(0, 2);
            rm = (rsel == 0) ? 162000 : (rsel == 1) ? 270000 : 540000;
            run("R10", $urandom_range(10000, 700000), $urandom_range(0, 7), rm,
                $urandom_range(0, 12), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), 0);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule